// File: doc/BRIEF.md
# Ring-Clocked Coarse Delay and Pulse Width Controller

This block is the digital control for one output channel of a multi-channel pulse generator. A trigger edge, taken from either an external reference or an internal synthesized clock, starts a sequence. The block enables an external delay-loop oscillator and counts its periods up to a programmed delay count. It raises the data input of the external output flip-flop one oscillator period before the target, so the analog flip-flop fires on the period that completes the count. The block then issues a one-cycle reset that clears the loop enable.

Once the output pulse is high, a second gated oscillator is enabled. Its periods are counted up to a programmed high-time count. A one-cycle end reset then clears the pulse path. The width-oscillator enable is kept high for a short hold-off so that the end reset cannot glitch. Other features:
- A zero delay count bypasses the loop.
- A burst limit stops the channel after a programmed number of pulses.
- A latched 10-bit fine-delay code is driven to an external fine delay element.

Both oscillators and the trigger are asynchronous to the control clock. Each is synchronized, and only its rising edges are counted. The oscillator periods must exceed the synchronizer and response latency, which is about four control-clock cycles.

Top module: `ring_delay_ctl`

## Requirements
- R1: The trigger source is `ext_trig` when `src_sel` is 0 and `int_clk` when `src_sel` is 1. Only a rising edge of the selected source starts a sequence; edges on the other source have no effect.
- R2: For an accepted trigger with nonzero `cfg_nd`, `loop_en` rises. `pulse_out` rises after exactly `cfg_nd` rising edges of `loop_osc` have been counted.
- R3: `ff_data` rises after `cfg_nd`−1 counted `loop_osc` edges, or at acceptance when `cfg_nd` is 1. `ff_data` is high in every cycle in which `pulse_out` is high.
- R4: `loop_rst` is high for exactly one cycle, the cycle in which `pulse_out` rises, and `loop_en` is low from the following cycle.
- R5: With `cfg_nd` equal to 0, `ff_data` and `pulse_out` rise together at acceptance with no `loop_osc` edge counted. `loop_en` and `loop_rst` stay low for that sequence.
- R6: `width_en` rises with `pulse_out`. `pulse_out` stays high until max(`cfg_nh`,1) rising edges of `width_osc` have been counted.
- R7: When the high-time count is reached, `end_rst` is high for one cycle. In the next cycle `pulse_out` and `ff_data` are low. `width_en` falls exactly HOLD_CYC clock cycles after `end_rst` rises.
- R8: When `cfg_burst` is nonzero and the number of completed pulses since reset or the last `flag_clr` has reached `cfg_burst`, triggers produce no pulse and do not set `overrun`. A `cfg_burst` of 0 means continuous operation.
- R9: `cfg_nd`, `cfg_nh` and `cfg_fine` are sampled only while no sequence is active. A change during a sequence has no effect on it; the change applies from the next trigger.
- R10: A trigger edge that arrives while a sequence is active, including its hold-off, is ignored and sets `overrun`. `overrun` stays set until `flag_clr`.
- R11: While idle, `fine_code` equals `cfg_fine` one clock cycle after it is applied. `fine_code` is held constant during a sequence.
- R12: After synchronous reset, all of the following are low: `ff_data`, `loop_en`, `loop_rst`, `pulse_out`, `end_rst`, `width_en`, `overrun` and `fine_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_trig | input | 1 | External reference trigger |
| int_clk | input | 1 | Internal synthesized trigger clock |
| src_sel | input | 1 | Trigger source select: 0 external, 1 internal |
| loop_osc | input | 1 | Delay-loop oscillator |
| width_osc | input | 1 | Gated width oscillator |
| cfg_nd | input | 12 | Coarse delay count |
| cfg_nh | input | 14 | High-time count |
| cfg_burst | input | 16 | Burst length; 0 means continuous |
| cfg_fine | input | 10 | Fine-delay code to latch |
| flag_clr | input | 1 | Clears `overrun` and the completed-pulse tally |
| ff_data | output | 1 | Data input of the external output flip-flop |
| loop_en | output | 1 | Delay-loop oscillator enable |
| loop_rst | output | 1 | One-cycle reset of the loop enable |
| pulse_out | output | 1 | Output pulse |
| end_rst | output | 1 | One-cycle end-of-pulse reset |
| width_en | output | 1 | Width-oscillator enable |
| fine_code | output | 10 | Latched fine-delay word |
| overrun | output | 1 | Sticky retrigger flag |

## Verification
The bench uses the default count widths, two synchronizer stages and a hold-off of six cycles. At these sizes a full sequence takes a few hundred cycles, so many randomized delay and high-time pairs fit in one run, alongside the corners at counts 0, 1 and 2.

The bench models both oscillators as gated generators. Each starts a fixed latency after its enable rises, and each has a period that never lines up with the control clock. The bench counts raw oscillator edges between the enable and the pulse transitions. This ties the delay and width counts directly to the oscillator periods.

Burst length 3 shows the cut-off and its release. A retrigger during a long delay shows the overrun path.

// File: rtl/rdc_pkg.sv
`timescale 1ns/1ps
// Shared types for the ring-clocked delay controller.
// Assumes: nothing beyond IEEE 1800-2017.
package rdc_pkg;

    // Sequence phase of one channel
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DELAY = 2'd1,
        ST_HIGH  = 2'd2,
        ST_HOLD  = 2'd3
    } seq_state_t;

    localparam int SRC_COUNT = 3;   // trigger, loop oscillator, width oscillator
    localparam int IDX_TRIG  = 0;
    localparam int IDX_LOOP  = 1;
    localparam int IDX_WIDTH = 2;

endpackage

// File: rtl/rdc_edge_sync.sv
`timescale 1ns/1ps
// Multi-flop synchronizer with rising-edge detect, one lane per input bit.
// Assumes: each input stays high and low for longer than one clk period,
// STAGES >= 2.
module rdc_edge_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] rise
);

    for (genvar g = 0; g < N; g++) begin : g_lane
        logic [STAGES-1:0] stg;
        logic              last;

        // Shift the raw level through the synchronizer and keep the previous level
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stg  <= '0;
                last <= 1'b0;
            end else begin
                stg  <= {stg[STAGES-2:0], raw[g]};
                last <= stg[STAGES-1];
            end
        end

        assign rise[g] = stg[STAGES-1] & ~last;
    end

endmodule

// File: rtl/rdc_span_cnt.sv
`timescale 1ns/1ps
// Tick counter for one span (delay or high time). Flags the tick that
// completes the span and the tick one before it.
// Assumes: lim is stable while run is high; a limit of 0 completes on the
// first tick.
module rdc_span_cnt #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] lim,
    output logic         hit,
    output logic         pre
);

    logic [W-1:0] cnt;
    logic [W-1:0] cnt_nxt;

    assign cnt_nxt = cnt + 1'b1;
    assign hit     = run & tick & (cnt_nxt >= lim);
    assign pre     = run & tick & (lim > W'(1)) & (cnt_nxt == lim - 1'b1);

    // Count ticks while running, restart whenever cleared
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (run && tick)
            cnt <= cnt_nxt;
    end

    AST_SPAN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (run && lim != '0) |-> (cnt < lim));   // R2

endmodule

// File: rtl/rdc_holdoff.sv
`timescale 1ns/1ps
// Hold-off timer. done is high in the CYC-th cycle of a run.
// Assumes: run stays high until done, CYC >= 1.
module rdc_holdoff #(
    parameter int CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);

    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt;

    assign done = run && (cnt == CW'(CYC - 1));

    // Count cycles of the current hold-off, idle at zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < CW'(CYC)));   // R7

endmodule

// File: rtl/ring_delay_ctl.sv
`timescale 1ns/1ps
// Control for one pulse-generator channel.
// - The coarse delay counts delay-loop oscillator periods; the pulse high
//   time counts width-oscillator periods.
// - Drives the external flip-flop data, the loop enable and its reset, the
//   end reset, the width-oscillator enable and the fine-delay word.
// - Supports a burst limit.
// Assumes: trigger and oscillator periods exceed about four clk cycles.
module ring_delay_ctl
    import rdc_pkg::*;
#(
    parameter int ND_W        = 12,
    parameter int NH_W        = 14,
    parameter int BURST_W     = 16,
    parameter int FINE_W      = 10,
    parameter int HOLD_CYC    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ext_trig,
    input  logic               int_clk,
    input  logic               src_sel,
    input  logic               loop_osc,
    input  logic               width_osc,
    input  logic [ND_W-1:0]    cfg_nd,
    input  logic [NH_W-1:0]    cfg_nh,
    input  logic [BURST_W-1:0] cfg_burst,
    input  logic [FINE_W-1:0]  cfg_fine,
    input  logic               flag_clr,
    output logic               ff_data,
    output logic               loop_en,
    output logic               loop_rst,
    output logic               pulse_out,
    output logic               end_rst,
    output logic               width_en,
    output logic [FINE_W-1:0]  fine_code,
    output logic               overrun
);

    localparam logic [BURST_W-1:0] TALLY_MAX = '1;

    seq_state_t         state;
    logic               trg_raw;
    logic [SRC_COUNT-1:0] raw_in;
    logic [SRC_COUNT-1:0] rise;
    logic               trg_rise;
    logic               loop_tick;
    logic               width_tick;
    logic               idle;
    logic               burst_done;
    logic               accept;
    logic               d_hit;
    logic               d_pre;
    logic               w_hit;
    logic               h_done;
    logic [ND_W-1:0]    sh_nd;
    logic [NH_W-1:0]    sh_nh;
    logic [FINE_W-1:0]  sh_fine;
    logic [BURST_W-1:0] tally;

    assign trg_raw = src_sel ? int_clk : ext_trig;
    assign raw_in  = {width_osc, loop_osc, trg_raw};

    rdc_edge_sync #(
        .N      (SRC_COUNT),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (raw_in),
        .rise  (rise)
    );

    assign trg_rise   = rise[IDX_TRIG];
    assign loop_tick  = rise[IDX_LOOP];
    assign width_tick = rise[IDX_WIDTH];

    assign idle       = (state == ST_IDLE);
    assign burst_done = (cfg_burst != '0) && (tally >= cfg_burst);
    assign accept     = idle && trg_rise && !burst_done;

    rdc_span_cnt #(.W(ND_W)) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state != ST_DELAY),
        .run   (state == ST_DELAY),
        .tick  (loop_tick),
        .lim   (sh_nd),
        .hit   (d_hit),
        .pre   (d_pre)
    );

    logic w_pre_unused;

    rdc_span_cnt #(.W(NH_W)) u_width (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state != ST_HIGH),
        .run   (state == ST_HIGH),
        .tick  (width_tick),
        .lim   (sh_nh),
        .hit   (w_hit),
        .pre   (w_pre_unused)
    );

    rdc_holdoff #(.CYC(HOLD_CYC)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_HOLD),
        .done  (h_done)
    );

    // Sample the configuration only between sequences
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_nd   <= '0;
            sh_nh   <= '0;
            sh_fine <= '0;
        end else if (idle) begin
            sh_nd   <= cfg_nd;
            sh_nh   <= cfg_nh;
            sh_fine <= cfg_fine;
        end
    end

    assign fine_code = sh_fine;

    // Sequence the delay, high and hold-off phases and drive the pulse path
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            ff_data   <= 1'b0;
            loop_en   <= 1'b0;
            loop_rst  <= 1'b0;
            pulse_out <= 1'b0;
            end_rst   <= 1'b0;
            width_en  <= 1'b0;
        end else begin
            loop_rst <= 1'b0;
            end_rst  <= 1'b0;
            if (loop_rst)
                loop_en <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        if (cfg_nd == '0) begin
                            ff_data   <= 1'b1;
                            pulse_out <= 1'b1;
                            width_en  <= 1'b1;
                            state     <= ST_HIGH;
                        end else begin
                            loop_en <= 1'b1;
                            ff_data <= (cfg_nd == ND_W'(1));
                            state   <= ST_DELAY;
                        end
                    end
                end
                ST_DELAY: begin
                    if (d_pre)
                        ff_data <= 1'b1;
                    if (d_hit) begin
                        ff_data   <= 1'b1;
                        pulse_out <= 1'b1;
                        loop_rst  <= 1'b1;
                        width_en  <= 1'b1;
                        state     <= ST_HIGH;
                    end
                end
                ST_HIGH: begin
                    if (w_hit) begin
                        end_rst <= 1'b1;
                        state   <= ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    if (end_rst) begin
                        pulse_out <= 1'b0;
                        ff_data   <= 1'b0;
                    end
                    if (h_done) begin
                        width_en <= 1'b0;
                        state    <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Tally completed pulses for the burst limit
    always_ff @(posedge clk) begin
        if (!rst_n)
            tally <= '0;
        else if (flag_clr)
            tally <= '0;
        else if (state == ST_HOLD && h_done && tally != TALLY_MAX)
            tally <= tally + 1'b1;
    end

    // Flag triggers that land inside an active sequence
    always_ff @(posedge clk) begin
        if (!rst_n)
            overrun <= 1'b0;
        else if (flag_clr)
            overrun <= 1'b0;
        else if (!idle && trg_rise)
            overrun <= 1'b1;
    end

    AST_ARMED_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_out |-> ff_data);   // R3
    AST_LOOP_RST_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        loop_rst |-> $rose(pulse_out));   // R4
    AST_LOOP_OFF_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
        loop_rst |=> (!loop_rst && !loop_en));   // R4
    AST_LOOP_IDLE_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_out && !loop_rst) |-> !loop_en);   // R5
    AST_WIDTH_EN_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_out |-> width_en);   // R6
    AST_END_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        end_rst |=> (!pulse_out && !ff_data && !end_rst));   // R7
    AST_WIDTH_EN_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(width_en) |-> !pulse_out);   // R7
    AST_FINE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(fine_code));   // R9
    AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> ($past(state) != ST_IDLE));   // R10

endmodule

// File: tb/test_ring_delay_ctl.sv
`timescale 1ns/1ps
// Self-checking bench: gated oscillator models, directed corners, random counts.
module test_ring_delay_ctl;

    localparam int HOLD = 6;
    localparam int WD_CYCLES = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_trig = 1'b0;
    logic        int_clk = 1'b0;
    logic        src_sel = 1'b0;
    logic        loop_osc = 1'b0;
    logic        width_osc = 1'b0;
    logic [11:0] cfg_nd = '0;
    logic [13:0] cfg_nh = '0;
    logic [15:0] cfg_burst = '0;
    logic [9:0]  cfg_fine = '0;
    logic        flag_clr = 1'b0;
    logic        ff_data, loop_en, loop_rst, pulse_out, end_rst, width_en, overrun;
    logic [9:0]  fine_code;

    int tests = 0;
    int fails = 0;

    ring_delay_ctl #(
        .HOLD_CYC    (HOLD),
        .SYNC_STAGES (2)
    ) i_ring_delay_ctl (
        .clk (clk), .rst_n (rst_n), .ext_trig (ext_trig), .int_clk (int_clk),
        .src_sel (src_sel), .loop_osc (loop_osc), .width_osc (width_osc),
        .cfg_nd (cfg_nd), .cfg_nh (cfg_nh), .cfg_burst (cfg_burst),
        .cfg_fine (cfg_fine), .flag_clr (flag_clr), .ff_data (ff_data),
        .loop_en (loop_en), .loop_rst (loop_rst), .pulse_out (pulse_out),
        .end_rst (end_rst), .width_en (width_en), .fine_code (fine_code),
        .overrun (overrun)
    );

    always #2.5 clk = ~clk;

    // Gated delay-loop oscillator: 35 ns period, starts 7.3 ns after enable
    initial begin
        forever begin
            @(posedge loop_en);
            #7.3;
            while (loop_en) begin
                loop_osc = 1'b1; #17.5;
                loop_osc = 1'b0; #17.5;
            end
        end
    end

    // Gated width oscillator: 40 ns period, starts 8.7 ns after enable
    initial begin
        forever begin
            @(posedge width_en);
            #8.7;
            while (width_en) begin
                width_osc = 1'b1; #20;
                width_osc = 1'b0; #20;
            end
        end
    end

    int n1 = 0, n2 = 0, np = 0, nlr = 0, nle = 0;
    int arm_at = 0, rise_at = 0, base2 = 0, hi_n2 = 0;
    int b1 = 0, blr = 0, ble = 0, bnp = 0;

    always @(posedge loop_osc)  n1++;
    always @(posedge width_osc) n2++;
    always @(posedge ff_data)   arm_at = n1;
    always @(posedge pulse_out) begin rise_at = n1; base2 = n2; np++; end
    always @(negedge pulse_out) hi_n2 = n2 - base2;
    always @(posedge loop_rst)  nlr++;
    always @(posedge loop_en)   nle++;

    function automatic int exp_arm(input int nd);
        return (nd == 0) ? 0 : nd - 1;
    endfunction

    function automatic int exp_hi(input int nh);
        return (nh == 0) ? 1 : nh;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic fire(input bit use_int);
        @(negedge clk);
        if (use_int) int_clk = 1'b1; else ext_trig = 1'b1;
        @(negedge clk);
        int_clk = 1'b0;
        ext_trig = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    task automatic start_seq(input bit use_int);
        repeat (4) @(negedge clk);
        b1 = n1; blr = nlr; ble = nle; bnp = np;
        fire(use_int);
    endtask

    task automatic finish_seq(input int nd, input int nh);
        int k;
        int hold;
        k = 0;
        while (end_rst !== 1'b1 && k < 5000) begin
            @(negedge clk);
            k++;
        end
        if (k >= 5000) begin
            chk("R2 sequence end not reached", 0, 1);
            return;
        end
        hold = 0;
        do begin
            @(negedge clk);
            hold++;
        end while (width_en && hold < 100);
        repeat (3) @(negedge clk);
        chk("R2 delay edges", rise_at - b1, nd);
        chk("R3 arm edges", arm_at - b1, exp_arm(nd));
        chk("R6 high edges", hi_n2, exp_hi(nh));
        chk("R7 hold-off cycles", hold, HOLD);
        chk("R4 loop reset pulses", nlr - blr, (nd != 0) ? 1 : 0);
        chk("R5 loop enables", nle - ble, (nd != 0) ? 1 : 0);
        chk("R1 pulses per trigger", np - bnp, 1);
    endtask

    task automatic run_seq(input int nd, input int nh, input bit use_int);
        cfg_nd = 12'(nd);
        cfg_nh = 14'(nh);
        start_seq(use_int);
        finish_seq(nd, nh);
    endtask

    task automatic ignored_fire(input string req, input bit use_int);
        bnp = np;
        fire(use_int);
        repeat (300) @(negedge clk);
        chk(req, np - bnp, 0);
    endtask

    // Watchdog: an expired run counts as a failure and still reports
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        fails++;
        $display("FAIL watchdog all requirements actual=expired expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        // R12: reset state
        chk("R12 outputs in reset",
            int'({ff_data, loop_en, loop_rst, pulse_out, end_rst, width_en, overrun}), 0);
        chk("R12 fine_code in reset", int'(fine_code), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R12 outputs after release",
            int'({ff_data, loop_en, loop_rst, pulse_out, end_rst, width_en, overrun}), 0);

        // Directed corners of delay and high time (R2 R3 R5 R6)
        run_seq(0, 0, 1'b0);
        run_seq(1, 1, 1'b0);
        run_seq(2, 5, 1'b0);
        run_seq(3, 0, 1'b0);

        // R11: fine word follows configuration while idle
        cfg_fine = 10'h2A5;
        repeat (2) @(negedge clk);
        chk("R11 fine_code idle", int'(fine_code), 'h2A5);

        // R9: configuration changes during a sequence apply only afterwards
        cfg_nd = 12'd12; cfg_nh = 14'd4; cfg_fine = 10'h155;
        start_seq(1'b0);
        repeat (10) @(negedge clk);
        cfg_nd = 12'd2; cfg_nh = 14'd9; cfg_fine = 10'h0F0;
        repeat (2) @(negedge clk);
        chk("R9 fine_code held during sequence", int'(fine_code), 'h155);
        finish_seq(12, 4);
        chk("R11 fine_code after sequence", int'(fine_code), 'h0F0);
        run_seq(2, 9, 1'b0);

        // R10: retrigger during a long delay is ignored and flagged
        cfg_nd = 12'd20; cfg_nh = 14'd3;
        start_seq(1'b0);
        repeat (10) @(negedge clk);
        fire(1'b0);
        repeat (2) @(negedge clk);
        chk("R10 overrun set", int'(overrun), 1);
        finish_seq(20, 3);
        chk("R10 overrun sticky", int'(overrun), 1);
        pulse_clear();
        chk("R10 overrun cleared", int'(overrun), 0);

        // R1: source select
        src_sel = 1'b1;
        ignored_fire("R1 unselected ext_trig", 1'b0);
        run_seq(4, 2, 1'b1);
        src_sel = 1'b0;
        ignored_fire("R1 unselected int_clk", 1'b1);

        // R8: burst of three pulses then silence, released by clear
        pulse_clear();
        cfg_burst = 16'd3;
        run_seq(2, 2, 1'b0);
        run_seq(1, 3, 1'b0);
        run_seq(0, 1, 1'b0);
        ignored_fire("R8 trigger after burst", 1'b0);
        ignored_fire("R8 second trigger after burst", 1'b0);
        chk("R8 no overrun after burst", int'(overrun), 0);
        pulse_clear();
        run_seq(3, 2, 1'b0);
        cfg_burst = 16'd0;

        // Random delay and high-time counts, continuous mode (R2 R3 R6 R8 R11)
        for (int i = 0; i < 12; i++) begin
            int rnd_nd;
            int rnd_nh;
            int rnd_f;
            rnd_nd = int'($urandom_range(0, 24));
            rnd_nh = int'($urandom_range(0, 24));
            rnd_f  = int'($urandom_range(0, 1023));
            cfg_fine = 10'(rnd_f);
            run_seq(rnd_nd, rnd_nh, 1'b0);
            chk("R11 fine_code random", int'(fine_code), rnd_f);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule